// File: doc/BRIEF.md
# Multiplexed-Strobe Block Access Controller

This controller gives a microprocessor random access to a line-organised field memory through two active-low strobes that share one 10-bit address bus. The falling row strobe loads the row and fixes whether the access reads or writes. The first falling column strobe after that loads the burst start column. Each further column strobe falling while the row strobe stays low moves one 12-bit word, up to eight per access. The column walks through the eight-word group that holds the start column and wraps inside that group. Write data is committed to the array when the row strobe rises.

The strobes are asynchronous to the controller. They pass through two-flop synchronisers, and edge detectors then work in the system clock domain. A column strobe that falls while the row strobe is high starts a refresh. When the row strobe then falls, the controller refreshes the row held in its own counter, which steps through every array row in turn. An active-low wait output holds the processor off for a fixed number of cycles after each address is latched. It also stays low for as long as the memory reports that a self-refresh left over from the streaming mode is still running. A high level on the mode input selects this access path. While the mode input is low, the controller ignores both strobes.

Top module: `blk_access_ctrl`

## Requirements
- R1: While `mode_blk` is low, strobe activity produces no array write, read, commit or refresh pulse. In that state `wait_n` stays high and `fifo_block` and `dq_oe` stay low, whatever the level of `self_ref_busy`.
- R2: A falling `ras_n` with `cas_n` high latches `addr`, and `arr_row` then carries its low 9 bits. The first falling `cas_n` after `wait_n` returns high latches `addr` as the burst start column.
- R3: Transfer k (k = 0..7) uses the column formed by the start column's bits [9:3] and the value (start[2:0] + k) mod 8. The controller transfers at most eight words per row-strobe low period and ignores any later column strobe.
- R4: The access is a write if `we_lo_n` or `we_hi_n` is low at the row-strobe fall, and a read if both are high. A write uses bank 0 when `we_lo_n` is low (this includes both low) and bank 1 when only `we_hi_n` is low.
- R5: A read uses bank 0 when row address bit 9 is 0 and bank 1 when it is 1. Each read transfer loads `arr_rdata` for the current column into `dq_out`.
- R6: `wait_n` goes low for SETUP_CYC cycles after each row or column latch. It also stays low while `self_ref_busy` is high in block mode. The controller ignores column strobes that fall while `wait_n` is low.
- R7: When `ras_n` rises after a write that moved at least one word, `arr_commit` pulses once with the row and bank of that access. A read gives no commit pulse.
- R8: A falling `cas_n` followed by a falling `ras_n` pulses `arr_refresh` with `arr_ref_row`. The row counter advances when `ras_n` rises and wraps from 289 to 0.
- R9: From the row latch until `ras_n` rises, `fifo_block` is high. During that time the controller ignores changes on the write enables, so a read never turns into a write.
- R10: `dq_oe` is high only during a read burst while `rd_en_n` is low.
- R11: After reset `wait_n` is high, `dq_oe` and `fifo_block` are low and `arr_ref_row` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_blk | input | 1 | High selects block access |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| addr | input | 10 | Shared row/column address |
| we_lo_n | input | 1 | Lower-bank write enable, active low |
| we_hi_n | input | 1 | Upper-bank write enable, active low |
| rd_en_n | input | 1 | Read output enable, active low |
| dq_in | input | 12 | Write data from processor |
| self_ref_busy | input | 1 | Pending self-refresh from streaming mode |
| arr_rdata | input | 12 | Read data from array at `arr_bank/arr_row/arr_col` |
| dq_out | output | 12 | Read data toward processor |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| wait_n | output | 1 | Low: processor must hold off |
| fifo_block | output | 1 | High: streaming operation must stall |
| arr_bank | output | 1 | Selected bank |
| arr_row | output | 9 | Selected row |
| arr_col | output | 10 | Column of the current burst word |
| arr_wdata | output | 12 | Write data toward array |
| arr_wr | output | 1 | One-cycle write strobe per word |
| arr_rd | output | 1 | One-cycle read strobe per word |
| arr_commit | output | 1 | Commit pulse at row-strobe rise after a write |
| arr_refresh | output | 1 | Refresh pulse |
| arr_ref_row | output | 9 | Row being refreshed |

## Verification
The checker tests several rules on every cycle. Block mode with a pending self-refresh must hold `wait_n` low, and no word may move while `wait_n` is low. The read and write strobes never fire together, any transfer sits inside a `fifo_block` window, and `dq_oe` follows `rd_en_n`. The checker also confirms that the refresh row moves only by one and wraps at the row count. Only the directed scenarios can show the rest. These are the exact column order inside the wrapped eight-word group, the bank picked from the write enables or from address bit 9, the ignored ninth strobe, commit after writes only, and a full pass of the refresh counter.

// File: rtl/blk_pkg.sv
package blk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CBR   = 3'd1,
    ST_REF   = 3'd2,
    ST_ROW   = 3'd3,
    ST_BURST = 3'd4
  } blk_state_t;
endpackage

// File: rtl/blk_edge_sync.sv
module blk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fell,
  output logic rose
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fell = last_q && !sync_q[STAGES-1];
  assign rose = !last_q && sync_q[STAGES-1];
endmodule

// File: rtl/blk_refresh_ctr.sv
module blk_refresh_ctr #(
  parameter int NUM_ROWS = 290
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  output logic [$clog2(NUM_ROWS)-1:0] row
);
  localparam int RW = $clog2(NUM_ROWS);

  function automatic logic [RW-1:0] next_row(input logic [RW-1:0] cur);
    return (cur == RW'(NUM_ROWS - 1)) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= next_row(row);
  end
endmodule

// File: rtl/blk_access_ctrl.sv
module blk_access_ctrl
  import blk_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 12,
  parameter int BURST_LEN = 8,
  parameter int NUM_ROWS  = 290,
  parameter int SETUP_CYC = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_blk,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        we_lo_n,
  input  logic                        we_hi_n,
  input  logic                        rd_en_n,
  input  logic [DATA_W-1:0]           dq_in,
  input  logic                        self_ref_busy,
  input  logic [DATA_W-1:0]           arr_rdata,
  output logic [DATA_W-1:0]           dq_out,
  output logic                        dq_oe,
  output logic                        wait_n,
  output logic                        fifo_block,
  output logic                        arr_bank,
  output logic [ADDR_W-2:0]           arr_row,
  output logic [ADDR_W-1:0]           arr_col,
  output logic [DATA_W-1:0]           arr_wdata,
  output logic                        arr_wr,
  output logic                        arr_rd,
  output logic                        arr_commit,
  output logic                        arr_refresh,
  output logic [$clog2(NUM_ROWS)-1:0] arr_ref_row
);
  localparam int IDX_W = $clog2(BURST_LEN);
  localparam int CNT_W = $clog2(SETUP_CYC + 1);

  // column of burst word idx: wraps inside the aligned group of the start
  function automatic logic [ADDR_W-1:0] burst_col(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0]  idx);
    logic [IDX_W-1:0] low;
    low = base[IDX_W-1:0] + idx;
    return {base[ADDR_W-1:IDX_W], low};
  endfunction

  blk_state_t        state;
  logic [ADDR_W-2:0] row_q;
  logic [ADDR_W-1:0] col_q;
  logic              is_wr;
  logic              bank_q;
  logic [CNT_W-1:0]  setup_cnt;
  logic [IDX_W:0]    wcnt;

  logic ras_fall, ras_rise, cas_fall, cas_rise;
  logic wait_free, xfer_ev, ref_step, in_access;

  blk_edge_sync #(.STAGES(2)) u_ras_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(ras_n), .fell(ras_fall), .rose(ras_rise));
  blk_edge_sync #(.STAGES(2)) u_cas_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(cas_n), .fell(cas_fall), .rose(cas_rise));

  blk_refresh_ctr #(.NUM_ROWS(NUM_ROWS)) u_ref_ctr (
    .clk(clk), .rst_n(rst_n), .step(ref_step), .row(arr_ref_row));

  // named internal events
  assign wait_free = (setup_cnt == '0) && !self_ref_busy;
  assign in_access = (state == ST_ROW) || (state == ST_BURST);
  assign xfer_ev   = mode_blk && (state == ST_BURST) && cas_fall && wait_free
                     && !ras_rise && (wcnt < (IDX_W+1)'(BURST_LEN));
  assign ref_step  = mode_blk && (state == ST_REF) && ras_rise;

  assign wait_n     = !mode_blk || wait_free;
  assign fifo_block = mode_blk && in_access;
  assign dq_oe      = mode_blk && (state == ST_BURST) && !is_wr && !rd_en_n;
  assign arr_bank   = bank_q;
  assign arr_row    = row_q;
  assign arr_col    = burst_col(col_q, wcnt[IDX_W-1:0]);
  assign arr_wdata  = dq_in;
  assign arr_wr     = xfer_ev && is_wr;
  assign arr_rd     = xfer_ev && !is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      is_wr       <= 1'b0;
      bank_q      <= 1'b0;
      setup_cnt   <= '0;
      wcnt        <= '0;
      dq_out      <= '0;
      arr_commit  <= 1'b0;
      arr_refresh <= 1'b0;
    end else begin
      arr_commit  <= 1'b0;
      arr_refresh <= 1'b0;
      if (setup_cnt != '0) setup_cnt <= setup_cnt - 1'b1;
      if (!mode_blk) begin
        state     <= ST_IDLE;
        setup_cnt <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (ras_fall) begin
              state     <= ST_ROW;
              row_q     <= addr[ADDR_W-2:0];
              is_wr     <= !(we_lo_n && we_hi_n);
              bank_q    <= (!(we_lo_n && we_hi_n)) ? we_lo_n : addr[ADDR_W-1];
              setup_cnt <= CNT_W'(SETUP_CYC);
            end else if (cas_fall) begin
              state <= ST_CBR;
            end
          end
          ST_CBR: begin
            if (ras_fall) begin
              state       <= ST_REF;
              arr_refresh <= 1'b1;
            end else if (cas_rise) begin
              state <= ST_IDLE;
            end
          end
          ST_REF: begin
            if (ras_rise) state <= ST_IDLE;
          end
          ST_ROW: begin
            if (ras_rise) begin
              state <= ST_IDLE;
            end else if (cas_fall && wait_free) begin
              state     <= ST_BURST;
              col_q     <= addr;
              wcnt      <= '0;
              setup_cnt <= CNT_W'(SETUP_CYC);
            end
          end
          ST_BURST: begin
            if (ras_rise) begin
              state      <= ST_IDLE;
              arr_commit <= is_wr && (wcnt != '0);
            end else if (xfer_ev) begin
              wcnt <= wcnt + 1'b1;
              if (!is_wr) dq_out <= arr_rdata;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/blk_access_chk.sv
module blk_access_chk #(
  parameter int NUM_ROWS = 290
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        mode_blk,
  input logic                        self_ref_busy,
  input logic                        rd_en_n,
  input logic                        wait_n,
  input logic                        fifo_block,
  input logic                        dq_oe,
  input logic                        arr_wr,
  input logic                        arr_rd,
  input logic                        arr_commit,
  input logic                        arr_refresh,
  input logic [$clog2(NUM_ROWS)-1:0] arr_ref_row
);
  localparam int RW = $clog2(NUM_ROWS);

  // R1
  fifo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_blk |-> !(arr_wr || arr_rd || fifo_block || dq_oe) && wait_n);
  // R6
  busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_blk && self_ref_busy) |-> !wait_n);
  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |-> !(arr_wr || arr_rd));
  // R4
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_wr, arr_rd}));
  // R9
  xfer_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr || arr_rd) |-> fifo_block);
  // R10
  oe_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!rd_en_n && fifo_block));
  // R7
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_commit |-> (!fifo_block && !arr_refresh));
  // R8
  ref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_ref_row < RW'(NUM_ROWS));
  // R8
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(arr_ref_row) |->
      arr_ref_row == (($past(arr_ref_row) == RW'(NUM_ROWS - 1)) ? '0 : $past(arr_ref_row) + 1'b1));
endmodule

bind blk_access_ctrl blk_access_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_blk(mode_blk), .self_ref_busy(self_ref_busy),
  .rd_en_n(rd_en_n), .wait_n(wait_n), .fifo_block(fifo_block), .dq_oe(dq_oe),
  .arr_wr(arr_wr), .arr_rd(arr_rd), .arr_commit(arr_commit),
  .arr_refresh(arr_refresh), .arr_ref_row(arr_ref_row));

// File: tb/blk_access_ctrl_tb.sv
module blk_access_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_blk = 1'b0, ras_n = 1'b1, cas_n = 1'b1;
  logic [9:0]  addr = '0;
  logic        we_lo_n = 1'b1, we_hi_n = 1'b1, rd_en_n = 1'b1, self_ref_busy = 1'b0;
  logic [11:0] dq_in = '0, arr_rdata, dq_out, arr_wdata;
  logic        dq_oe, wait_n, fifo_block, arr_bank, arr_wr, arr_rd, arr_commit, arr_refresh;
  logic [8:0]  arr_row, arr_ref_row;
  logic [9:0]  arr_col;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0, cm_cnt = 0, rf_cnt = 0;
  logic [9:0]  lw_col;
  logic [11:0] lw_data;
  logic        lw_bank, cm_bank;
  logic [8:0]  cm_row, rf_row;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // array data model: distinct value per location
  function automatic logic [11:0] pat(input logic b, input logic [8:0] r, input logic [9:0] c);
    return {b, r[4:0], c[5:0]};
  endfunction
  assign arr_rdata = pat(arr_bank, arr_row, arr_col);

  function automatic logic [9:0] exp_col(input logic [9:0] start, input int k);
    return (start & 10'h3F8) | ((start + 10'(k)) & 10'h007);
  endfunction

  blk_access_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_blk(mode_blk), .ras_n(ras_n), .cas_n(cas_n),
    .addr(addr), .we_lo_n(we_lo_n), .we_hi_n(we_hi_n), .rd_en_n(rd_en_n),
    .dq_in(dq_in), .self_ref_busy(self_ref_busy), .arr_rdata(arr_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe), .wait_n(wait_n), .fifo_block(fifo_block),
    .arr_bank(arr_bank), .arr_row(arr_row), .arr_col(arr_col), .arr_wdata(arr_wdata),
    .arr_wr(arr_wr), .arr_rd(arr_rd), .arr_commit(arr_commit),
    .arr_refresh(arr_refresh), .arr_ref_row(arr_ref_row));

  always @(posedge clk) begin
    if (arr_wr) begin
      wr_cnt <= wr_cnt + 1; lw_col <= arr_col; lw_data <= arr_wdata; lw_bank <= arr_bank;
    end
    if (arr_rd) rd_cnt <= rd_cnt + 1;
    if (arr_commit) begin cm_cnt <= cm_cnt + 1; cm_bank <= arr_bank; cm_row <= arr_row; end
    if (arr_refresh) begin rf_cnt <= rf_cnt + 1; rf_row <= arr_ref_row; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic ras_open(input logic [9:0] row, input logic lo_n, input logic hi_n);
    addr = row; we_lo_n = lo_n; we_hi_n = hi_n; ras_n = 1'b0;
    tick(3);
    chk(wait_n == 1'b0, "R6 wait low after row", wait_n, 0);
    tick(9);
    chk(wait_n == 1'b1, "R6 wait high after setup", wait_n, 1);
    chk(fifo_block == 1'b1, "R9 fifo_block in access", fifo_block, 1);
  endtask

  task automatic col_set(input logic [9:0] col);
    addr = col; cas_n = 1'b0; tick(4); cas_n = 1'b1; tick(10);
  endtask

  task automatic xfer(input logic [11:0] d);
    dq_in = d; cas_n = 1'b0; tick(4); cas_n = 1'b1; tick(3);
  endtask

  task automatic ras_close();
    ras_n = 1'b1; we_lo_n = 1'b1; we_hi_n = 1'b1; tick(6);
  endtask

  task automatic t_reset();
    chk(wait_n == 1'b1, "R11 wait_n", wait_n, 1);
    chk(dq_oe == 1'b0, "R11 dq_oe", dq_oe, 0);
    chk(fifo_block == 1'b0, "R11 fifo_block", fifo_block, 0);
    chk(arr_ref_row == 9'd0, "R11 ref row", arr_ref_row, 0);
  endtask

  task automatic t_fifo_ignored();
    int w0 = wr_cnt, r0 = rd_cnt, c0 = cm_cnt, f0 = rf_cnt;
    mode_blk = 1'b0; self_ref_busy = 1'b1;
    tick(1);
    chk(wait_n == 1'b1, "R1 wait high in fifo mode", wait_n, 1);
    addr = 10'h005; we_lo_n = 1'b0; ras_n = 1'b0; tick(12);
    chk(fifo_block == 1'b0, "R1 no block in fifo mode", fifo_block, 0);
    for (int i = 0; i < 3; i++) xfer(12'hABC);
    ras_close();
    cas_n = 1'b0; tick(4); ras_n = 1'b0; tick(4); ras_n = 1'b1; tick(4); cas_n = 1'b1; tick(4);
    chk((wr_cnt == w0) && (rd_cnt == r0) && (cm_cnt == c0) && (rf_cnt == f0),
        "R1 no array events", wr_cnt + rd_cnt + cm_cnt + rf_cnt, w0 + r0 + c0 + f0);
    self_ref_busy = 1'b0; mode_blk = 1'b1; tick(2);
  endtask

  task automatic t_write(input logic lo_n, input logic hi_n, input logic [9:0] row,
                         input logic [9:0] col, input logic exp_bank);
    int w0 = wr_cnt, c0 = cm_cnt;
    rd_en_n = 1'b1;
    ras_open(row, lo_n, hi_n);
    col_set(col);
    for (int k = 0; k < 8; k++) begin
      logic [11:0] d = 12'h300 + 12'(k * 17) + {2'b0, col};
      xfer(d);
      chk(wr_cnt == w0 + k + 1, "R3 write word count", wr_cnt, w0 + k + 1);
      chk(lw_col == exp_col(col, k), "R3 write column order", lw_col, exp_col(col, k));
      chk(lw_data == d, "R2 write data", lw_data, d);
      chk(lw_bank == exp_bank, "R4 write bank", lw_bank, exp_bank);
    end
    xfer(12'hFFF);
    chk(wr_cnt == w0 + 8, "R3 ninth strobe ignored", wr_cnt, w0 + 8);
    ras_close();
    chk(cm_cnt == c0 + 1, "R7 commit once", cm_cnt, c0 + 1);
    chk(cm_row == row[8:0], "R2 commit row", cm_row, row[8:0]);
    chk(cm_bank == exp_bank, "R7 commit bank", cm_bank, exp_bank);
  endtask

  task automatic t_read(input logic [9:0] row, input logic [9:0] col, input bit poke_we);
    int w0 = wr_cnt, c0 = cm_cnt, r0 = rd_cnt;
    logic b = row[9];
    rd_en_n = 1'b0;
    ras_open(row, 1'b1, 1'b1);
    col_set(col);
    if (poke_we) begin we_lo_n = 1'b0; we_hi_n = 1'b0; end
    for (int k = 0; k < 8; k++) begin
      xfer(12'h000);
      chk(dq_out == pat(b, row[8:0], exp_col(col, k)), "R5 read data",
          dq_out, pat(b, row[8:0], exp_col(col, k)));
    end
    chk(rd_cnt == r0 + 8, "R3 read word count", rd_cnt, r0 + 8);
    chk(dq_oe == 1'b1, "R10 oe during read", dq_oe, 1);
    rd_en_n = 1'b1; tick(1);
    chk(dq_oe == 1'b0, "R10 oe off with rd_en_n high", dq_oe, 0);
    if (poke_we) begin
      chk(wr_cnt == w0, "R9 write enables ignored mid-read", wr_cnt, w0);
      chk(fifo_block == 1'b1, "R9 still blocked", fifo_block, 1);
    end
    ras_close();
    chk(cm_cnt == c0, "R7 no commit after read", cm_cnt, c0);
  endtask

  task automatic t_self_ref_wait();
    int w0 = wr_cnt;
    self_ref_busy = 1'b1; tick(1);
    chk(wait_n == 1'b0, "R6 wait low while self-refresh pending", wait_n, 0);
    self_ref_busy = 1'b0; tick(1);
    ras_open(10'h011, 1'b0, 1'b1);
    col_set(10'h020);
    self_ref_busy = 1'b1;
    xfer(12'h111);
    chk(wr_cnt == w0, "R6 strobe ignored while wait low", wr_cnt, w0);
    self_ref_busy = 1'b0; tick(1);
    xfer(12'h222);
    chk(wr_cnt == w0 + 1, "R6 strobe accepted after wait", wr_cnt, w0 + 1);
    chk(lw_col == 10'h020, "R3 first column after wait", lw_col, 10'h020);
    ras_close();
  endtask

  task automatic t_refresh();
    int f0 = rf_cnt;
    for (int i = 0; i < 291; i++) begin
      cas_n = 1'b0; tick(4); ras_n = 1'b0; tick(4);
      if (i == 0)   chk(rf_row == 9'd0, "R8 first refresh row", rf_row, 0);
      if (i == 289) chk(rf_row == 9'd289, "R8 last refresh row", rf_row, 289);
      if (i == 290) chk(rf_row == 9'd0, "R8 refresh wrap", rf_row, 0);
      ras_n = 1'b1; tick(4); cas_n = 1'b1; tick(4);
    end
    chk(rf_cnt == f0 + 291, "R8 refresh pulse count", rf_cnt, f0 + 291);
    chk(arr_ref_row == 9'd1, "R8 counter after wrap", arr_ref_row, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_sim();
    end
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_fifo_ignored();
    t_write(1'b0, 1'b1, 10'h00A, 10'h00D, 1'b0);
    t_write(1'b1, 1'b0, 10'h0F3, 10'h158, 1'b1);
    t_write(1'b0, 1'b0, 10'h122, 10'h3FF, 1'b0);
    t_read(10'h007, 10'h022, 1'b0);
    t_read(10'h21C, 10'h0AE, 1'b1);
    t_self_ref_wait();
    t_refresh();
    done = 1;
    finish_sim();
  end
endmodule